// File: doc/BRIEF.md
# Dual-Mode Indirect Host Register Port

This block connects an 8-bit host bus to a wide internal memory through a handful of external registers. The host sees eight external locations on a 3-bit address. Through them it loads a 10-bit internal address, a 6-bit channel field and a memory-map select bit, and then moves 24-bit words one byte at a time. The internal memory is never addressed directly. Every internal transfer runs as a fixed-length cycle on a simple request interface that the block drives.

Internal transfers are triggered by the order of accesses. Writing the two upper data bytes only stages them. Writing the lowest data byte launches the internal write with all three bytes. Reading the lowest data byte launches an internal read, which captures the whole word at once, so the two upper bytes can be read afterwards from the same snapshot.

A style input chooses between two host bus conventions. In the first, separate read and write strobes are used and a ready line drops while an internal cycle is busy. In the second, a data strobe is used together with a read/not-write line, and an acknowledge line drops on completion and is held until the strobe is removed. The host strobes are synchronised to the block clock. Several accesses may follow one another while chip select stays asserted.

Top module: `indirect_host_port`

## Requirements
- R1: After reset, `host_ack` is high, `mem_req` is low, and every external register reads back as zero.
- R2: External location 6 (low address byte) and location 7 (control: bits 1:0 are internal address bits 9:8, bits 7:2 are the channel) read back exactly as written. Location 3 keeps only bit 5, and the other bits read as zero. Locations 4 and 5 ignore writes and read zero.
- R3: An internal cycle presents address {control[1:0], low byte}, channel control[7:2] and map select location3[5], whichever of control and low byte was written first.
- R4: Writes to data locations 2 and 1 only stage bytes and start no internal cycle. A write to data location 0 starts an internal write of {loc2, loc1, written byte}.
- R5: A read of data location 0 starts an internal read and returns bits 7:0 of the word. Later reads of locations 1 and 2 return bits 15:8 and 23:16 of that same captured word and start no internal cycle, even if the memory has changed since.
- R6: Each internal cycle holds `mem_req` high for exactly CYCLE_LEN clocks, with address, channel, map, direction and write data stable for the whole cycle. The read data is taken in its last clock.
- R7: With `bus_style` = 0, the strobes are `rd_ds_n` (read) and `wr_rw_n` (write), active low. `host_ack` is low while an internal cycle is running and high otherwise, so it stays high for accesses that start no internal cycle.
- R8: With `bus_style` = 1, `rd_ds_n` is the data strobe and `wr_rw_n` is high for a read and low for a write. `host_ack` goes low when the access completes (at once for a register access, at the end of the internal cycle for a trigger) and stays low until the strobe is removed.
- R9: Accesses take effect only while `cs_n` is low. Any number of accesses may be chained with `cs_n` held low, each one framed by a new strobe pulse.
- R10: A trigger that arrives while an internal cycle is running is ignored. It starts no cycle and does not change the staged or transferred data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_style | input | 1 | 0: separate read/write strobes; 1: data strobe with read/not-write |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| wr_rw_n | input | 1 | Write strobe (style 0) or read/not-write (style 1) |
| host_addr | input | 3 | External register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed location |
| host_ack | output | 1 | Ready (style 0) or acknowledge (style 1), low when active |
| mem_req | output | 1 | Internal cycle in progress |
| mem_we | output | 1 | Internal cycle direction, 1 = write |
| mem_map | output | 1 | Memory map select: 0 channel map, 1 output port map |
| mem_chan | output | 6 | Channel field from the control register |
| mem_addr | output | 10 | Internal word address |
| mem_wdata | output | 24 | Internal write word |
| mem_rdata | input | 24 | Internal read word, sampled in the last cycle clock |

## Verification
The assertions rely on the host holding `host_addr`, `host_wdata` and the style stable while a strobe is asserted. They also rely on `bus_style` changing only while no strobe is active and no cycle is running, and on the memory returning its data within the fixed cycle. The bench keeps to these assumptions. It changes inputs only on falling edges. It waits out the synchroniser before it reads data or the handshake, and it switches style only from the idle state. The one deliberate exception is a second trigger pulse issued inside a running internal cycle, which checks that the trigger is ignored.

// File: rtl/ihp_pkg.sv
package ihp_pkg;

    localparam int HOST_DW = 8;
    localparam int HOST_AW = 3;
    localparam int INT_AW  = 10;
    localparam int WORD_W  = 24;
    localparam int CHAN_W  = 6;
    localparam int NUM_DR  = WORD_W / HOST_DW;
    localparam int UPPER_W = INT_AW - HOST_DW;
    localparam int MAP_BIT = 5;

    typedef enum logic [HOST_AW-1:0] {
        EA_D0   = 3'd0,
        EA_D1   = 3'd1,
        EA_D2   = 3'd2,
        EA_MAP  = 3'd3,
        EA_SP4  = 3'd4,
        EA_SP5  = 3'd5,
        EA_LOW  = 3'd6,
        EA_CTL  = 3'd7
    } ext_addr_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    typedef struct packed {
        logic              we;
        logic              map;
        logic [CHAN_W-1:0] chan;
        logic [INT_AW-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } icmd_t;

    function automatic strobe_t decode_strobes(input logic style, input logic cs_n,
                                               input logic rd_n, input logic wr_n);
        strobe_t s;
        if (style) begin
            s.rd = !cs_n && !rd_n && wr_n;
            s.wr = !cs_n && !rd_n && !wr_n;
        end else begin
            s.rd = !cs_n && !rd_n;
            s.wr = !cs_n && !wr_n && rd_n;
        end
        return s;
    endfunction

    function automatic logic [INT_AW-1:0] join_addr(input logic [HOST_DW-1:0] ctl,
                                                    input logic [HOST_DW-1:0] low);
        return {ctl[UPPER_W-1:0], low};
    endfunction

endpackage

// File: rtl/ihp_sync.sv
module ihp_sync
    import ihp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    style,
    input  logic    cs_n,
    input  logic    rd_n,
    input  logic    wr_n,
    output strobe_t strb,
    output logic    start,
    output logic    ds_act
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] pipe_q [SYNC_STAGES];
    logic            act_prev_q;
    logic            act_now;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= '1;
                    else     pipe_q[g] <= {cs_n, rd_n, wr_n};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= '1;
                    else     pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        strb    = decode_strobes(style, pipe_q[SYNC_STAGES-1][2],
                                 pipe_q[SYNC_STAGES-1][1], pipe_q[SYNC_STAGES-1][0]);
        act_now = strb.rd || strb.wr;
        ds_act  = !pipe_q[SYNC_STAGES-1][2] && !pipe_q[SYNC_STAGES-1][1];
        start   = act_now && !act_prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) act_prev_q <= 1'b0;
        else     act_prev_q <= act_now;
    end

endmodule

// File: rtl/ihp_regs.sv
module ihp_regs
    import ihp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  strobe_t            strb,
    input  logic               busy,
    input  logic               done_rd,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [HOST_DW-1:0] rdata_out,
    output logic               launch,
    output icmd_t              cmd
);
    logic [HOST_DW-1:0] stage_q [NUM_DR];
    logic [HOST_DW-1:0] low_q;
    logic [HOST_DW-1:0] ctl_q;
    logic               map_q;
    logic [WORD_W-1:0]  snap_q;
    logic [WORD_W-1:0]  word_out;
    logic               do_wr;
    logic               do_rd;
    logic               trig;

    assign do_wr = start && strb.wr;
    assign do_rd = start && strb.rd;
    assign trig  = (ext_addr_e'(addr) == EA_D0) && (do_wr || do_rd);
    assign launch = trig && !busy;

    always_comb begin
        word_out = '0;
        word_out[HOST_DW-1:0] = wdata;
        for (int k = 1; k < NUM_DR; k++) begin
            word_out[k*HOST_DW +: HOST_DW] = stage_q[k];
        end
        cmd.we    = do_wr;
        cmd.map   = map_q;
        cmd.chan  = ctl_q[HOST_DW-1:UPPER_W];
        cmd.addr  = join_addr(ctl_q, low_q);
        cmd.wdata = word_out;
    end

    generate
        for (genvar g = 0; g < NUM_DR; g++) begin : g_stage
            if (g == 0) begin : g_unused
                always_ff @(posedge clk) begin
                    stage_q[g] <= '0;
                end
            end else begin : g_byte
                always_ff @(posedge clk) begin
                    if (rst)
                        stage_q[g] <= '0;
                    else if (do_wr && (addr == HOST_AW'(g)))
                        stage_q[g] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= '0;
            ctl_q  <= '0;
            map_q  <= 1'b0;
            snap_q <= '0;
        end else begin
            if (do_wr) begin
                unique case (ext_addr_e'(addr))
                    EA_LOW:  low_q <= wdata;
                    EA_CTL:  ctl_q <= wdata;
                    EA_MAP:  map_q <= wdata[MAP_BIT];
                    default: ;
                endcase
            end
            if (done_rd) snap_q <= mem_rdata;
        end
    end

    always_comb begin
        rdata_out = '0;
        unique case (ext_addr_e'(addr))
            EA_D0:   rdata_out = snap_q[0*HOST_DW +: HOST_DW];
            EA_D1:   rdata_out = snap_q[1*HOST_DW +: HOST_DW];
            EA_D2:   rdata_out = snap_q[2*HOST_DW +: HOST_DW];
            EA_MAP:  rdata_out[MAP_BIT] = map_q;
            EA_LOW:  rdata_out = low_q;
            EA_CTL:  rdata_out = ctl_q;
            default: rdata_out = '0;
        endcase
    end

    // R2: unused locations never return data
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ((ext_addr_e'(addr) == EA_SP4) || (ext_addr_e'(addr) == EA_SP5)) |-> (rdata_out == '0));

endmodule

// File: rtl/ihp_engine.sv
module ihp_engine
    import ihp_pkg::*;
#(
    parameter int CYCLE_LEN = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  launch,
    input  icmd_t cmd_in,
    output logic  busy,
    output logic  done,
    output icmd_t cmd_q
);
    localparam int CW = $clog2(CYCLE_LEN + 1);

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == CW'(CYCLE_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else if (launch && !busy) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            cmd_q <= cmd_in;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the request fields stay put for the whole cycle
    p_cmd_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(done)) |-> $stable(cmd_q));

    // R10: the register block never launches into a running cycle
    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

endmodule

// File: rtl/ihp_handshake.sv
module ihp_handshake (
    input  logic clk,
    input  logic rst,
    input  logic style,
    input  logic busy,
    input  logic done,
    input  logic start,
    input  logic launch,
    input  logic ds_act,
    output logic ack
);
    logic dt_low_q;

    always_ff @(posedge clk) begin
        if (rst)
            dt_low_q <= 1'b0;
        else if (!ds_act)
            dt_low_q <= 1'b0;
        else if (done || (start && !launch))
            dt_low_q <= 1'b1;
    end

    assign ack = style ? !dt_low_q : !busy;

    // R8: acknowledge is released once the data strobe is gone
    p_dtack_release_r8: assert property (@(posedge clk) disable iff (rst)
        (style && $past(style) && !ds_act) |=> ack);

endmodule

// File: rtl/indirect_host_port.sv
module indirect_host_port
    import ihp_pkg::*;
#(
    parameter int CYCLE_LEN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_style,
    input  logic                cs_n,
    input  logic                rd_ds_n,
    input  logic                wr_rw_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                host_ack,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_map,
    output logic [CHAN_W-1:0]   mem_chan,
    output logic [INT_AW-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata
);
    strobe_t strb;
    logic    start;
    logic    ds_act;
    logic    launch;
    logic    busy;
    logic    done;
    logic    done_rd;
    icmd_t   cmd_new;
    icmd_t   cmd_q;

    ihp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .style(bus_style),
        .cs_n(cs_n), .rd_n(rd_ds_n), .wr_n(wr_rw_n),
        .strb(strb), .start(start), .ds_act(ds_act)
    );

    ihp_regs u_regs (
        .clk(clk), .rst(rst), .start(start), .strb(strb),
        .busy(busy), .done_rd(done_rd),
        .addr(host_addr), .wdata(host_wdata), .mem_rdata(mem_rdata),
        .rdata_out(host_rdata), .launch(launch), .cmd(cmd_new)
    );

    ihp_engine #(.CYCLE_LEN(CYCLE_LEN)) u_engine (
        .clk(clk), .rst(rst), .launch(launch), .cmd_in(cmd_new),
        .busy(busy), .done(done), .cmd_q(cmd_q)
    );

    ihp_handshake u_hs (
        .clk(clk), .rst(rst), .style(bus_style), .busy(busy), .done(done),
        .start(start), .launch(launch), .ds_act(ds_act), .ack(host_ack)
    );

    assign done_rd   = done && !cmd_q.we;
    assign mem_req   = busy;
    assign mem_we    = cmd_q.we;
    assign mem_map   = cmd_q.map;
    assign mem_chan  = cmd_q.chan;
    assign mem_addr  = cmd_q.addr;
    assign mem_wdata = cmd_q.wdata;

    // R7: in style 0 a launched cycle pulls ready low on the next clock
    p_ready_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_style && $past(!bus_style) && launch) |=> !host_ack);

endmodule

// File: tb/indirect_host_port_tb.sv
module indirect_host_port_tb;
    import ihp_pkg::*;

    localparam int CYC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_style = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_ds_n = 1'b1;
    logic        wr_rw_n = 1'b1;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic        mem_req, mem_we, mem_map;
    logic [5:0]  mem_chan;
    logic [9:0]  mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata;

    logic [23:0] mem_model [2048];
    icmd_t       exp_q [$];
    int          checks = 0;
    int          errors = 0;
    int          req_seen = 0;
    int          run_len = 0;
    logic        req_prev = 1'b0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    indirect_host_port #(.CYCLE_LEN(CYC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_style(bus_style), .cs_n(cs_n),
        .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_map(mem_map), .mem_chan(mem_chan),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_model[{mem_map, mem_addr}];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_req && mem_we) mem_model[{mem_map, mem_addr}] <= mem_wdata;
            if (mem_req && !req_prev) begin
                req_seen++;
                run_len = 1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected internal cycle", 32'(mem_addr), 0);
                end else begin
                    icmd_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we, "R4", "cycle direction", 32'(mem_we), 32'(e.we));
                    chk(mem_addr == e.addr && mem_chan == e.chan && mem_map == e.map, "R3",
                        "cycle address/chan/map", {15'd0, mem_map, mem_chan, mem_addr},
                        {15'd0, e.map, e.chan, e.addr});
                    if (e.we)
                        chk(mem_wdata == e.wdata, "R4", "write word", 32'(mem_wdata), 32'(e.wdata));
                end
            end else if (mem_req) begin
                run_len++;
            end else if (req_prev) begin
                chk(run_len == CYC, "R6", "cycle length", 32'(run_len), 32'(CYC));
            end
            req_prev <= mem_req;
        end
    end

    task automatic push_cmd(input bit we, input logic [7:0] ctl, input logic [7:0] low,
                            input bit map, input logic [23:0] w);
        icmd_t e;
        e.we = we; e.map = map; e.chan = ctl[7:2]; e.addr = {ctl[1:0], low}; e.wdata = w;
        exp_q.push_back(e);
    endtask

    // style 0 access with cs_n already low; returns read data and whether ready dropped
    task automatic acc0(input bit wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q, output bit saw_low);
        saw_low = 1'b0;
        @(negedge clk);
        host_addr = a; host_wdata = d;
        if (wr) wr_rw_n = 1'b0; else rd_ds_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (!host_ack) saw_low = 1'b1;
        end
        while (!host_ack) begin
            saw_low = 1'b1;
            @(negedge clk);
        end
        q = host_rdata;
        wr_rw_n = 1'b1; rd_ds_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // style 1 access; checks the acknowledge hold and release
    task automatic acc1(input bit wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q);
        @(negedge clk);
        host_addr = a; host_wdata = d; wr_rw_n = !wr;
        @(negedge clk);
        rd_ds_n = 1'b0;
        while (host_ack) @(negedge clk);
        q = host_rdata;
        repeat (5) @(negedge clk);
        chk(host_ack == 1'b0, "R8", "ack held while strobe asserted", 32'(host_ack), 0);
        rd_ds_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(host_ack == 1'b1, "R8", "ack released after strobe", 32'(host_ack), 1);
        wr_rw_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        bit         lo;
        int         base;
        for (int i = 0; i < 2048; i++) mem_model[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(host_ack == 1'b1, "R1", "ack after reset", 32'(host_ack), 1);
        chk(mem_req == 1'b0, "R1", "no cycle after reset", 32'(mem_req), 0);
        for (int a = 0; a < 8; a++) begin
            host_addr = 3'(a);
            #1;
            chk(host_rdata == 8'h00, "R1", "register after reset", 32'(host_rdata), 0);
        end

        // R9: strobe with chip select high does nothing
        acc0(1'b1, 3'd6, 8'hFF, q, lo);
        cs_n = 1'b0;
        acc0(1'b0, 3'd6, 8'h00, q, lo);
        chk(q == 8'h00, "R9", "write ignored without chip select", 32'(q), 0);

        // R2 register readback, chained with cs_n low
        acc0(1'b1, 3'd6, 8'h5A, q, lo);
        acc0(1'b0, 3'd6, 8'h00, q, lo);
        chk(q == 8'h5A, "R2", "low address readback", 32'(q), 32'h5A);
        chk(lo == 1'b0, "R7", "ready stays high on register access", 32'(lo), 0);
        acc0(1'b1, 3'd7, 8'hC7, q, lo);
        acc0(1'b0, 3'd7, 8'h00, q, lo);
        chk(q == 8'hC7, "R2", "control readback", 32'(q), 32'hC7);
        acc0(1'b1, 3'd3, 8'hFF, q, lo);
        acc0(1'b0, 3'd3, 8'h00, q, lo);
        chk(q == 8'h20, "R2", "map register keeps bit 5 only", 32'(q), 32'h20);
        acc0(1'b1, 3'd4, 8'hFF, q, lo);
        acc0(1'b0, 3'd4, 8'h00, q, lo);
        chk(q == 8'h00, "R2", "location 4 reads zero", 32'(q), 0);
        acc0(1'b1, 3'd5, 8'hFF, q, lo);
        acc0(1'b0, 3'd5, 8'h00, q, lo);
        chk(q == 8'h00, "R2", "location 5 reads zero", 32'(q), 0);

        // R4 staged write then trigger
        base = req_seen;
        acc0(1'b1, 3'd2, 8'hAB, q, lo);
        acc0(1'b1, 3'd1, 8'hCD, q, lo);
        chk(req_seen == base, "R4", "staging starts no cycle", 32'(req_seen), 32'(base));
        push_cmd(1'b1, 8'hC7, 8'h5A, 1'b1, 24'hABCDEF);
        acc0(1'b1, 3'd0, 8'hEF, q, lo);
        chk(lo == 1'b1, "R7", "ready low during internal write", 32'(lo), 1);
        chk(mem_model[{1'b1, 10'h35A}] == 24'hABCDEF, "R4", "memory written",
            32'(mem_model[{1'b1, 10'h35A}]), 32'hABCDEF);

        // R3 low address before control, map 0
        acc0(1'b1, 3'd6, 8'h10, q, lo);
        acc0(1'b1, 3'd7, 8'h01, q, lo);
        acc0(1'b1, 3'd3, 8'h00, q, lo);
        acc0(1'b1, 3'd2, 8'h12, q, lo);
        acc0(1'b1, 3'd1, 8'h34, q, lo);
        push_cmd(1'b1, 8'h01, 8'h10, 1'b0, 24'h123456);
        acc0(1'b1, 3'd0, 8'h56, q, lo);
        chk(mem_model[{1'b0, 10'h110}] == 24'h123456, "R3", "write lands at joined address",
            32'(mem_model[{1'b0, 10'h110}]), 32'h123456);

        // R5 read snapshot
        acc0(1'b1, 3'd6, 8'h22, q, lo);
        mem_model[{1'b0, 10'h122}] = 24'h9A7B3C;
        push_cmd(1'b0, 8'h01, 8'h22, 1'b0, 24'h0);
        acc0(1'b0, 3'd0, 8'h00, q, lo);
        chk(q == 8'h3C, "R5", "low byte of read", 32'(q), 32'h3C);
        chk(lo == 1'b1, "R7", "ready low during internal read", 32'(lo), 1);
        mem_model[{1'b0, 10'h122}] = 24'h000000;
        base = req_seen;
        acc0(1'b0, 3'd1, 8'h00, q, lo);
        chk(q == 8'h7B, "R5", "middle byte from snapshot", 32'(q), 32'h7B);
        acc0(1'b0, 3'd2, 8'h00, q, lo);
        chk(q == 8'h9A, "R5", "upper byte from snapshot", 32'(q), 32'h9A);
        chk(req_seen == base, "R5", "upper reads start no cycle", 32'(req_seen), 32'(base));

        // R10 second trigger inside a running cycle
        base = req_seen;
        push_cmd(1'b1, 8'h01, 8'h22, 1'b0, 24'h123411);
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 8'h11; wr_rw_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_rw_n = 1'b1;
        repeat (2) @(negedge clk);
        host_wdata = 8'h22; wr_rw_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_ack == 1'b0, "R10", "cycle still running at retrigger", 32'(host_ack), 0);
        while (!host_ack) @(negedge clk);
        wr_rw_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(req_seen == base + 1, "R10", "only one cycle launched", 32'(req_seen), 32'(base + 1));
        chk(mem_model[{1'b0, 10'h122}] == 24'h123411, "R10", "first trigger data kept",
            32'(mem_model[{1'b0, 10'h122}]), 32'h123411);

        // R8 style 1
        cs_n = 1'b1;
        bus_style = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        acc1(1'b1, 3'd2, 8'h01, q);
        acc1(1'b1, 3'd1, 8'h02, q);
        push_cmd(1'b1, 8'h01, 8'h22, 1'b0, 24'h010203);
        acc1(1'b1, 3'd0, 8'h03, q);
        chk(mem_model[{1'b0, 10'h122}] == 24'h010203, "R8", "write via data strobe",
            32'(mem_model[{1'b0, 10'h122}]), 32'h010203);
        mem_model[{1'b0, 10'h122}] = 24'hC0FFEE;
        push_cmd(1'b0, 8'h01, 8'h22, 1'b0, 24'h0);
        acc1(1'b0, 3'd0, 8'h00, q);
        chk(q == 8'hEE, "R8", "read via read/not-write high", 32'(q), 32'hEE);
        acc1(1'b0, 3'd2, 8'h00, q);
        chk(q == 8'hC0, "R5", "upper byte in style 1", 32'(q), 32'hC0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all expected cycles seen", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule